// File: doc/BRIEF.md
# TDM Channel Slot Mask Allocator

This block decides which time slots of a multi-lane TDM link carry the channels of an audio stream. Each lane offers up to 32 slots, and a 32-bit availability mask per lane says which of them may be used. After a start pulse, the engine takes the channel count and hands channels out to available slots. It produces one 32-bit result mask per lane with a bit set for every slot that carries a channel.

Slots are handed out two at a time. The walk goes over slot pairs (0,1), (2,3) and so on up to (30,31). For each pair it visits every lane in ascending order before it moves to the next pair. Inside a lane the lower slot of the pair is tried first. Because of this pair-interleaved order, a given channel lands in the same slot whatever the total channel count. The engine does one (pair, lane) step per clock. It pulses `done_o` when the count is used up or the walk ends. If channels are left over after the last step, it raises `err_o`.

Top module: `tdm_slot_alloc`

## Requirements
- R1: After reset `slots_o` is all zero and `done_o` and `err_o` are low.
- R2: The walk order is fixed. The outer loop goes over slot pairs 0..15, where pair p is slots 2p and 2p+1. For each pair the lanes are visited in ascending order, and the lower slot is tried before the higher one. A slot is granted only if its bit is set in that lane's availability mask. Lane L's slots sit at bits L*32 .. L*32+31 of both `avail_i` and `slots_o`, and slot s is bit s within the lane.
- R3: Each granted slot sets its bit in the lane's result mask and lowers the remaining count by one. No slot is granted once the count reaches zero. The total number of set result bits is therefore the smaller of the channel count and the number of available slots.
- R4: An accepted start clears every result mask before any slot is granted, so bits from an earlier run never carry over.
- R5: `err_o` is high with the done pulse, and stays high afterwards, exactly when channels remain after all 16 pairs of all lanes have been walked. Otherwise it is low.
- R6: The engine does one (pair, lane) step per clock. Let S be the number of steps taken, counting up to and including the step where the count reaches zero (16*NUM_LANES if it never does). Then `done_o` is first high just after the (S+1)-th rising edge, counting the edge that samples the start as the first.
- R7: `done_o` is high for exactly one cycle. `slots_o` and `err_o` then hold their values until the next accepted start.
- R8: A start pulse that arrives while a run is in progress is ignored. The running walk and its results are not affected.
- R9: A start with a channel count of zero finishes after one edge. The result masks are all zero and there is no error.
- R10: The availability masks are captured when a start is accepted. Changes on `avail_i` during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| ch_count_i | input | CH_W | Number of channels to place |
| avail_i | input | NUM_LANES*32 | Available-slot masks, lane L at bits L*32 and up |
| slots_o | output | NUM_LANES*32 | Granted-slot masks, same layout |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Channels could not all be placed |

## Verification
The assertions check on every cycle that no result bit is ever set outside the captured availability mask and that the done signal is a single-cycle pulse. They also check that results and the error flag hold while idle, that the captured masks do not move during a run, that a zero-count start completes on the next cycle, and that an error is only reported when channels remain. The exact placement produced by the pair-interleaved order, the cycle at which done arrives for a given walk length, the clearing of old results on a new start, and the rejection of a start or a mask change in the middle of a run can only be shown by the bench's scenarios. The bench compares each of these against its own reference walk.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  localparam int LANE_SLOTS = 32;
  localparam int PAIRS      = LANE_SLOTS / 2;
  localparam int PAIR_W     = $clog2(PAIRS);
endpackage

// File: rtl/tdm_walk_ctrl.sv
// Walks (pair, lane) steps: lanes inner, pairs outer, one step per clock.
module tdm_walk_ctrl #(
  parameter int NUM_LANES = 4,
  localparam int LANE_W   = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int PAIR_W   = tdm_slot_pkg::PAIR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  input  logic              stop_i,
  output logic              busy_o,
  output logic [PAIR_W-1:0] pair_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              last_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(tdm_slot_pkg::PAIRS - 1);

  logic              busy_q;
  logic [PAIR_W-1:0] pair_q;
  logic [LANE_W-1:0] lane_q;

  assign last_o = busy_q && (lane_q == LAST_LANE) && (pair_q == LAST_PAIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pair_q <= '0;
      lane_q <= '0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_q <= 1'b1;
        pair_q <= '0;
        lane_q <= '0;
      end
    end else if (stop_i || last_o) begin
      busy_q <= 1'b0;
    end else if (lane_q == LAST_LANE) begin
      lane_q <= '0;
      pair_q <= pair_q + 1'b1;
    end else begin
      lane_q <= lane_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign pair_o = pair_q;
  assign lane_o = lane_q;

  // R6: a step never addresses a lane beyond the configured count
  p_lane_range_r6: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (lane_q <= LAST_LANE));

  // R6: a new walk always begins at pair 0, lane 0
  p_walk_begin_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && launch_i) |=> (busy_q && pair_q == '0 && lane_q == '0));
endmodule

// File: rtl/tdm_pair_grant.sv
// Grants the two slots of one pair in one lane, lower slot first.
module tdm_pair_grant #(
  parameter int CH_W = 8
) (
  input  logic [1:0]      avail_i,
  input  logic [CH_W-1:0] rem_i,
  output logic [1:0]      grant_o,
  output logic [CH_W-1:0] rem_o
);
  logic [CH_W-1:0] rem_mid;

  always_comb begin
    grant_o[0] = avail_i[0] && (rem_i != '0);
    rem_mid    = rem_i - CH_W'(grant_o[0]);
    grant_o[1] = avail_i[1] && (rem_mid != '0);
    rem_o      = rem_mid - CH_W'(grant_o[1]);
  end
endmodule

// File: rtl/tdm_slot_alloc.sv
module tdm_slot_alloc #(
  parameter int NUM_LANES = 4,
  parameter int CH_W      = 8,
  localparam int MW       = NUM_LANES * tdm_slot_pkg::LANE_SLOTS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [CH_W-1:0] ch_count_i,
  input  logic [MW-1:0]   avail_i,
  output logic [MW-1:0]   slots_o,
  output logic            done_o,
  output logic            err_o
);
  import tdm_slot_pkg::*;
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic [LANE_SLOTS-1:0] avail_q [NUM_LANES];
  logic [LANE_SLOTS-1:0] slots_q [NUM_LANES];
  logic [MW-1:0]         avail_flat;
  logic [CH_W-1:0]       rem_q, rem_nxt;
  logic                  done_q, err_q;
  logic                  busy, last_step, stop, accept;
  logic [PAIR_W-1:0]     pair;
  logic [LANE_W-1:0]     lane;
  logic [1:0]            av_pair, grant;

  assign accept = start_i && !busy;

  tdm_walk_ctrl #(.NUM_LANES(NUM_LANES)) u_walk (
    .clk      (clk),
    .rst      (rst),
    .launch_i (accept && (ch_count_i != '0)),
    .stop_i   (stop),
    .busy_o   (busy),
    .pair_o   (pair),
    .lane_o   (lane),
    .last_o   (last_step)
  );

  assign av_pair = avail_q[lane][{pair, 1'b0} +: 2];

  tdm_pair_grant #(.CH_W(CH_W)) u_grant (
    .avail_i (av_pair),
    .rem_i   (rem_q),
    .grant_o (grant),
    .rem_o   (rem_nxt)
  );

  assign stop = busy && (rem_nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      for (int l = 0; l < NUM_LANES; l++) begin
        avail_q[l] <= '0;
        slots_q[l] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q <= ch_count_i;
        err_q <= 1'b0;
        for (int l = 0; l < NUM_LANES; l++) begin
          avail_q[l] <= avail_i[l*LANE_SLOTS +: LANE_SLOTS];
          slots_q[l] <= '0;
        end
        if (ch_count_i == '0) done_q <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_nxt;
        slots_q[lane][{pair, 1'b0} +: 2] <= slots_q[lane][{pair, 1'b0} +: 2] | grant;
        if (stop) begin
          done_q <= 1'b1;
        end else if (last_step) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign slots_o[g*LANE_SLOTS +: LANE_SLOTS]    = slots_q[g];
    assign avail_flat[g*LANE_SLOTS +: LANE_SLOTS] = avail_q[g];
  end

  assign done_o = done_q;
  assign err_o  = err_q;

  // R2: a result bit is never set where the captured mask has no slot
  p_grant_avail_r2: assert property (@(posedge clk) disable iff (rst)
    (slots_o & ~avail_flat) == '0);

  // R3: the remaining count never grows during a walk
  p_rem_mono_r3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (rem_q <= $past(rem_q)));

  // R5: an error is only reported with channels left over
  p_err_rem_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> (rem_q != '0));

  // R7: done is a one-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7: results and error hold while idle with no start
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_i) |=> ($stable(slots_o) && $stable(err_q)));

  // R8, R10: captured masks do not move during a run
  p_mask_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(avail_flat));

  // R9: zero-count start completes at once, empty and error-free
  p_zero_count_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && ch_count_i == '0) |=> (done_q && !busy && slots_o == '0 && !err_q));
endmodule

// File: tb/tdm_slot_alloc_tb.sv
module tdm_slot_alloc_tb;
  localparam int NL = 4;
  localparam int CW = 8;
  localparam int MW = NL * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [CW-1:0] ch_count_i = '0;
  logic [MW-1:0] avail_i = '0;
  logic [MW-1:0] slots_o;
  logic          done_o, err_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  tdm_slot_alloc #(.NUM_LANES(NL), .CH_W(CW)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .ch_count_i(ch_count_i),
    .avail_i(avail_i), .slots_o(slots_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference walk: pairs outer, lanes inner, lower slot first
  task automatic model(input int cnt, input logic [MW-1:0] av,
                       output logic [MW-1:0] m, output int s, output bit e);
    int rem = cnt;
    m = '0;
    s = 0;
    for (int p = 0; p < 16; p++)
      for (int l = 0; l < NL; l++)
        if (rem > 0) begin
          s++;
          for (int k = 0; k < 2; k++)
            if (av[l*32 + 2*p + k] && rem > 0) begin
              m[l*32 + 2*p + k] = 1'b1;
              rem--;
            end
        end
    e = (rem > 0);
  endtask

  // Generic run; optionally pokes start/avail at edge number poke_at
  task automatic run(input int cnt, input logic [MW-1:0] av, input string req,
                     input int poke_at, input int p_cnt, input logic [MW-1:0] p_av);
    logic [MW-1:0] em;
    int es, edges;
    bit ee;
    model(cnt, av, em, es, ee);
    @(negedge clk);
    start_i = 1'b1; ch_count_i = CW'(cnt); avail_i = av;
    @(posedge clk); edges = 1;
    @(negedge clk); start_i = 1'b0;
    while (!done_o && edges < 200) begin
      if (edges == poke_at) begin
        start_i = 1'b1; ch_count_i = CW'(p_cnt); avail_i = p_av;
      end
      @(posedge clk); edges++;
      @(negedge clk); start_i = 1'b0;
    end
    chk(edges == es + 1, {req, " R6 latency"}, MW'(edges), MW'(es + 1));
    chk(slots_o == em, {req, " mask"}, slots_o, em);
    chk(err_o == ee, {req, " R5 err"}, MW'(err_o), MW'(ee));
    @(negedge clk);
    chk(!done_o, "R7 done pulse width", MW'(done_o), '0);
    repeat (3) @(negedge clk);
    chk(slots_o == em && err_o == ee, "R7 hold after done", slots_o, em);
  endtask

  task automatic t_reset();
    chk(slots_o == '0 && !done_o && !err_o, "R1 reset state", slots_o, '0);
  endtask

  task automatic t_full_small();
    // R2: 5 channels all available -> lane0 s0,s1; lane1 s0,s1; lane2 s0
    logic [MW-1:0] exp = '0;
    exp[0] = 1; exp[1] = 1; exp[32] = 1; exp[33] = 1; exp[64] = 1;
    run(5, '1, "R2 full mask", -1, 0, '0);
    chk(slots_o == exp, "R2 explicit order", slots_o, exp);
  endtask

  task automatic t_sparse();
    logic [MW-1:0] av = '0;
    av[1] = 1; av[5] = 1; av[32+2] = 1; av[32+3] = 1; av[96+31] = 1; av[64+0] = 1;
    run(4, av, "R2 sparse", -1, 0, '0);
    run(6, {4{32'hA5A5_0F0F}}, "R3 pattern", -1, 0, '0);
  endtask

  task automatic t_exact_fit();
    logic [MW-1:0] av = '0;
    av[3] = 1; av[40] = 1; av[95] = 1;
    run(3, av, "R5 exact fit", -1, 0, '0);
  endtask

  task automatic t_overflow();
    logic [MW-1:0] av = '0;
    av[7] = 1; av[70] = 1;
    run(3, av, "R5 overflow", -1, 0, '0);
  endtask

  task automatic t_zero();
    run(0, '1, "R9 zero count", -1, 0, '0);
    chk(slots_o == '0, "R9 zero mask", slots_o, '0);
  endtask

  task automatic t_clear();
    run(100, '1, "R3 large", -1, 0, '0);
    run(2, {96'h0, 32'h0000_0300}, "R4 clear on start", -1, 0, '0);
  endtask

  task automatic t_busy_start();
    run(40, '1, "R8 start while busy", 3, 1, {MW{1'b0}});
  endtask

  task automatic t_mask_change();
    run(20, {4{32'h0000_FFFF}}, "R10 mask change", 4, 20, {4{32'hFFFF_0000}});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_small();
    t_sparse();
    t_exact_fit();
    t_overflow();
    t_zero();
    t_clear();
    t_busy_start();
    t_mask_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule